// File: doc/BRIEF.md
# Descriptor Table Register Unit

This unit holds the locating registers for three in-memory descriptor tables: a global table, an interrupt table and a local table. It turns segment selectors and interrupt vectors into the byte address of an 8-byte descriptor. Each lookup is checked against the table limit. A selector that points at global entry zero is reported as null.

Software writes the global and interrupt registers directly and can read them back in full. The local table register is loaded with a 16-bit selector. The unit then reads the matching descriptor out of the global table over a simple request/valid memory handshake. It caches that descriptor's base and limit, and uses them for later local lookups.

While a local load is in flight the unit reports busy and accepts neither lookups nor further loads. The cached base and limit change together, only at the end of a successful fetch.

Top module: `desc_table_unit`

## Requirements
- R1: A write with `tab_wr_sel`=0 replaces the global register and with `tab_wr_sel`=1 replaces the interrupt register. Each register packs the base in bits 47:16 and the limit in bits 15:0, and reads back unchanged on `gtab_q` / `itab_q` from the cycle after the write. The other register keeps its value.
- R2: A selector lookup (`lk_is_vec`=0) uses bits 15:3 as the index and bit 2 as the table choice (0 = global, 1 = local). It answers with `lk_ack` one cycle after acceptance, with status 0 (ok) and address = table base + index*8.
- R3: A global lookup with index 0 returns status 1 (null) and address 0. Index 0 of the local table is an ordinary entry.
- R4: A selector lookup whose entry end offset index*8+7 exceeds the table limit returns status 2 (limit) and address 0. An end offset equal to the limit is accepted. This applies to the 16-bit global limit and to the 20-bit cached local limit.
- R5: A vector lookup (`lk_is_vec`=1, vector in `lk_key[7:0]`) returns interrupt base + v*8. It returns status 2 when v*8+7 exceeds the interrupt limit.
- R6: A local lookup while the local table is invalid returns status 3 (rejected).
- R7: Loading the local register reports its outcome on `lload_done` one cycle after acceptance, with no memory read, in two cases. A selector with bit 2 = 1 gives status 3 and leaves the local state unchanged. A null selector (index 0) gives status 1, stores the selector and marks the local table invalid.
- R8: Any other load compares the entry end offset against the global limit. If it exceeds the limit, the load gives status 2 with no memory read. Otherwise `mem_req` rises one cycle after acceptance with `mem_addr` = global base + index*8, and both stay stable until `mem_valid`.
- R9: In the returned descriptor the base is {bits 63:56, 39:32, 31:16}, the limit is {bits 51:48, 15:0} and the present flag is bit 47. If the flag is 0, the load gives status 3 and the local state is unchanged. If the flag is 1, the selector, base and limit are stored together, the table becomes valid and the status is 0. `lload_done` pulses one cycle after `mem_valid`.
- R10: `busy` is high exactly while a fetch is pending. Lookup and load requests made while busy are dropped: no `lk_ack` and no new load.
- R11: After reset, both table registers and all local state are zero, the local table is invalid, and `mem_req`, `busy`, `lk_ack` and `lload_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tab_wr_en | input | 1 | Table register write strobe |
| tab_wr_sel | input | 1 | 0 = global register, 1 = interrupt register |
| tab_wr_data | input | 48 | Write value: base 47:16, limit 15:0 |
| gtab_q | output | 48 | Global register readback |
| itab_q | output | 48 | Interrupt register readback |
| lk_req | input | 1 | Lookup request |
| lk_is_vec | input | 1 | 1 = interrupt vector lookup, 0 = selector lookup |
| lk_key | input | 16 | Selector, or vector in bits 7:0 |
| lk_ack | output | 1 | Lookup result valid |
| lk_status | output | 2 | 0 ok, 1 null, 2 limit, 3 rejected |
| lk_addr | output | 32 | Descriptor byte address (0 on any fault) |
| lload_req | input | 1 | Load local register request |
| lload_sel | input | 16 | Selector to load |
| lload_done | output | 1 | Load finished pulse |
| lload_status | output | 2 | 0 ok, 1 null, 2 limit, 3 rejected |
| busy | output | 1 | Descriptor fetch pending |
| lsel_q | output | 16 | Local register selector |
| lbase_q | output | 32 | Cached local base |
| llim_q | output | 20 | Cached local limit |
| lvalid_q | output | 1 | Local table valid |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor read address |
| mem_valid | input | 1 | Read data valid |
| mem_data | input | 64 | Descriptor read data |

## Verification
Assertions check several rules on every cycle. The fetch request and its address stay stable until data returns. The cached base and limit move only at fetch completion. An absent descriptor or a local-table selector never alters local state. A lookup made while busy gets no acknowledge, and a global index-zero lookup always reports null. Only the directed scenarios can show the arithmetic results: exact addresses for each table, the limit boundary at offset equal to the limit, the field extraction from a returned descriptor, and readback after writes. They also show the sequence effects, such as a null load invalidating the local table for later lookups.

// File: rtl/dtu_pkg.sv
// Package: shared types for the descriptor table register unit.
// Assumes: status codes are visible at the top ports as 2-bit values.
package dtu_pkg;

    typedef enum logic [1:0] {
        ST_OK    = 2'd0,
        ST_NULL  = 2'd1,
        ST_LIMIT = 2'd2,
        ST_BAD   = 2'd3
    } dt_status_e;

    typedef enum logic {
        LD_IDLE  = 1'b0,
        LD_FETCH = 1'b1
    } ld_state_e;

endpackage

// File: rtl/dtu_lookup.sv
// Module: dtu_lookup
// Turns a selector or vector into a descriptor address with limit and
// null checks, and registers the result for one cycle of latency.
// Assumes: req is already gated by the caller (no request while busy);
// DLIM_W is at least as wide as SEL_W and TLIM_W.
module dtu_lookup
    import dtu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TLIM_W = 16,
    parameter int DLIM_W = 20,
    parameter int SEL_W  = 16,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              is_vec,
    input  logic [SEL_W-1:0]  key,
    input  logic [ADDR_W-1:0] gbase,
    input  logic [TLIM_W-1:0] glim,
    input  logic [ADDR_W-1:0] ibase,
    input  logic [TLIM_W-1:0] ilim,
    input  logic [ADDR_W-1:0] lbase,
    input  logic [DLIM_W-1:0] llim,
    input  logic              lvalid,
    output logic              ack,
    output dt_status_e        status,
    output logic [ADDR_W-1:0] addr
);
    localparam int IDX_W = SEL_W - 3;
    localparam int CMP_W = DLIM_W;

    logic [IDX_W-1:0]   idx;
    logic               in_local;
    logic [VEC_W-1:0]   vec;
    logic [SEL_W-1:0]   sel_end;
    logic [VEC_W+2:0]   vec_end;
    logic [SEL_W-1:0]   sel_off;
    logic [VEC_W+2:0]   vec_off;
    logic [ADDR_W-1:0]  unused_key_hi;
    dt_status_e         nx_status;
    logic [ADDR_W-1:0]  nx_addr;

    assign idx      = key[SEL_W-1:3];
    assign in_local = key[2];
    assign vec      = key[VEC_W-1:0];
    assign sel_off  = {idx, 3'b000};
    assign sel_end  = {idx, 3'b111};
    assign vec_off  = {vec, 3'b000};
    assign vec_end  = {vec, 3'b111};
    assign unused_key_hi = '0;

    // Decide the status and address of the requested entry.
    always_comb begin
        nx_status = ST_OK;
        nx_addr   = '0;
        if (is_vec) begin
            if (CMP_W'(vec_end) > CMP_W'(ilim)) nx_status = ST_LIMIT;
            else nx_addr = ibase + ADDR_W'(vec_off);
        end else if (!in_local) begin
            if (idx == '0) nx_status = ST_NULL;
            else if (CMP_W'(sel_end) > CMP_W'(glim)) nx_status = ST_LIMIT;
            else nx_addr = gbase + ADDR_W'(sel_off);
        end else begin
            if (!lvalid) nx_status = ST_BAD;
            else if (CMP_W'(sel_end) > CMP_W'(llim)) nx_status = ST_LIMIT;
            else nx_addr = lbase + ADDR_W'(sel_off);
        end
    end

    // Register the result and raise the acknowledge for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack    <= 1'b0;
            status <= ST_OK;
            addr   <= '0;
        end else begin
            ack <= req;
            if (req) begin
                status <= nx_status;
                addr   <= nx_addr;
            end
        end
    end

    AST_NULL_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !is_vec && !key[2] && key[SEL_W-1:3] == '0)
        |=> (ack && status == ST_NULL && addr == '0)); // R3

    AST_LOCAL_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !is_vec && key[2] && !lvalid)
        |=> (ack && status == ST_BAD)); // R6

    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && status != ST_OK) |-> (addr == '0)); // R4

endmodule

// File: rtl/dtu_local_loader.sv
// Module: dtu_local_loader
// Loads the local table register: validates the selector, reads the
// matching descriptor from the global table and caches base and limit.
// Assumes: ld_req is already gated by the caller while busy; memory holds
// mem_data valid for the single cycle mem_valid is high.
module dtu_local_loader
    import dtu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TLIM_W = 16,
    parameter int DLIM_W = 20,
    parameter int SEL_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_req,
    input  logic [SEL_W-1:0]  ld_sel,
    input  logic [ADDR_W-1:0] gbase,
    input  logic [TLIM_W-1:0] glim,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [63:0]       mem_data,
    output logic              busy,
    output logic              ld_done,
    output dt_status_e        ld_status,
    output logic [SEL_W-1:0]  lsel,
    output logic [ADDR_W-1:0] lbase,
    output logic [DLIM_W-1:0] llim,
    output logic              lvalid
);
    localparam int IDX_W   = SEL_W - 3;
    localparam int CMP_W   = DLIM_W;
    localparam int PRES_B  = 47;

    ld_state_e          state;
    logic [SEL_W-1:0]   pend_sel;
    logic [IDX_W-1:0]   idx;
    logic [SEL_W-1:0]   sel_end;
    logic               over_limit;
    logic [31:0]        d_base;
    logic [19:0]        d_lim;
    logic               d_present;
    logic               unused_desc_bits;

    assign idx        = ld_sel[SEL_W-1:3];
    assign sel_end    = {idx, 3'b111};
    assign over_limit = CMP_W'(sel_end) > CMP_W'(glim);
    assign d_base     = {mem_data[63:56], mem_data[39:32], mem_data[31:16]};
    assign d_lim      = {mem_data[51:48], mem_data[15:0]};
    assign d_present  = mem_data[PRES_B];
    assign unused_desc_bits = ^{mem_data[55:52], mem_data[46:40]};
    assign mem_req    = (state == LD_FETCH);
    assign busy       = (state == LD_FETCH);

    // Sequence a load: quick rejects from idle, else fetch then commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= LD_IDLE;
            pend_sel  <= '0;
            mem_addr  <= '0;
            ld_done   <= 1'b0;
            ld_status <= ST_OK;
            lsel      <= '0;
            lbase     <= '0;
            llim      <= '0;
            lvalid    <= 1'b0;
        end else begin
            ld_done <= 1'b0;
            case (state)
                LD_IDLE: begin
                    if (ld_req) begin
                        if (ld_sel[2]) begin
                            ld_done   <= 1'b1;
                            ld_status <= ST_BAD;
                        end else if (idx == '0) begin
                            ld_done   <= 1'b1;
                            ld_status <= ST_NULL;
                            lsel      <= ld_sel;
                            lvalid    <= 1'b0;
                        end else if (over_limit) begin
                            ld_done   <= 1'b1;
                            ld_status <= ST_LIMIT;
                        end else begin
                            state    <= LD_FETCH;
                            pend_sel <= ld_sel;
                            mem_addr <= gbase + ADDR_W'({idx, 3'b000});
                        end
                    end
                end
                LD_FETCH: begin
                    if (mem_valid) begin
                        state   <= LD_IDLE;
                        ld_done <= 1'b1;
                        if (!d_present) begin
                            ld_status <= ST_BAD;
                        end else begin
                            ld_status <= ST_OK;
                            lsel      <= pend_sel;
                            lbase     <= ADDR_W'(d_base);
                            llim      <= DLIM_W'(d_lim);
                            lvalid    <= 1'b1;
                        end
                    end
                end
                default: state <= LD_IDLE;
            endcase
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr))); // R8

    AST_CACHE_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(lbase) && $stable(llim))); // R9

    AST_ABSENT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_valid && !mem_data[PRES_B])
        |=> ($stable(lvalid) && $stable(lsel) && ld_done && ld_status == ST_BAD)); // R9

    AST_TI_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && !busy && ld_sel[2])
        |=> (!mem_req && ld_done && ld_status == ST_BAD && $stable(lsel))); // R7

endmodule

// File: rtl/desc_table_unit.sv
// Module: desc_table_unit (top)
// Holds the global and interrupt table registers, and gates lookups and
// local loads while a descriptor fetch is pending.
// Assumes: register writes are accepted in any cycle, including while busy.
module desc_table_unit
    import dtu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TLIM_W = 16,
    parameter int DLIM_W = 20,
    parameter int SEL_W  = 16,
    parameter int VEC_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tab_wr_en,
    input  logic                     tab_wr_sel,
    input  logic [ADDR_W+TLIM_W-1:0] tab_wr_data,
    output logic [ADDR_W+TLIM_W-1:0] gtab_q,
    output logic [ADDR_W+TLIM_W-1:0] itab_q,
    input  logic                     lk_req,
    input  logic                     lk_is_vec,
    input  logic [SEL_W-1:0]         lk_key,
    output logic                     lk_ack,
    output logic [1:0]               lk_status,
    output logic [ADDR_W-1:0]        lk_addr,
    input  logic                     lload_req,
    input  logic [SEL_W-1:0]         lload_sel,
    output logic                     lload_done,
    output logic [1:0]               lload_status,
    output logic                     busy,
    output logic [SEL_W-1:0]         lsel_q,
    output logic [ADDR_W-1:0]        lbase_q,
    output logic [DLIM_W-1:0]        llim_q,
    output logic                     lvalid_q,
    output logic                     mem_req,
    output logic [ADDR_W-1:0]        mem_addr,
    input  logic                     mem_valid,
    input  logic [63:0]              mem_data
);
    localparam int TAB_W = ADDR_W + TLIM_W;

    logic [TAB_W-1:0] gtab;
    logic [TAB_W-1:0] itab;
    logic             lk_go;
    logic             ld_go;
    dt_status_e       lk_st;
    dt_status_e       ld_st;

    // Hold the software-written global and interrupt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gtab <= '0;
            itab <= '0;
        end else if (tab_wr_en) begin
            if (tab_wr_sel) itab <= tab_wr_data;
            else            gtab <= tab_wr_data;
        end
    end

    assign gtab_q = gtab;
    assign itab_q = itab;
    assign lk_go  = lk_req && !busy;
    assign ld_go  = lload_req && !busy;

    dtu_lookup #(
        .ADDR_W(ADDR_W), .TLIM_W(TLIM_W), .DLIM_W(DLIM_W),
        .SEL_W(SEL_W), .VEC_W(VEC_W)
    ) lookup_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (lk_go),
        .is_vec (lk_is_vec),
        .key    (lk_key),
        .gbase  (gtab[TAB_W-1:TLIM_W]),
        .glim   (gtab[TLIM_W-1:0]),
        .ibase  (itab[TAB_W-1:TLIM_W]),
        .ilim   (itab[TLIM_W-1:0]),
        .lbase  (lbase_q),
        .llim   (llim_q),
        .lvalid (lvalid_q),
        .ack    (lk_ack),
        .status (lk_st),
        .addr   (lk_addr)
    );

    dtu_local_loader #(
        .ADDR_W(ADDR_W), .TLIM_W(TLIM_W), .DLIM_W(DLIM_W), .SEL_W(SEL_W)
    ) loader_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_req    (ld_go),
        .ld_sel    (lload_sel),
        .gbase     (gtab[TAB_W-1:TLIM_W]),
        .glim      (gtab[TLIM_W-1:0]),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_valid (mem_valid),
        .mem_data  (mem_data),
        .busy      (busy),
        .ld_done   (lload_done),
        .ld_status (ld_st),
        .lsel      (lsel_q),
        .lbase     (lbase_q),
        .llim      (llim_q),
        .lvalid    (lvalid_q)
    );

    assign lk_status    = lk_st;
    assign lload_status = ld_st;

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && busy) |=> !lk_ack); // R10

    AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (tab_wr_en && !tab_wr_sel) |=> (gtab_q == $past(tab_wr_data))); // R1

    AST_BUSY_IS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> mem_req); // R10

endmodule

// File: tb/desc_table_unit_tb_top.sv
// Directed bench for desc_table_unit: one task per scenario.
module desc_table_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tab_wr_en = 1'b0;
    logic        tab_wr_sel = 1'b0;
    logic [47:0] tab_wr_data = '0;
    logic [47:0] gtab_q, itab_q;
    logic        lk_req = 1'b0;
    logic        lk_is_vec = 1'b0;
    logic [15:0] lk_key = '0;
    logic        lk_ack;
    logic [1:0]  lk_status;
    logic [31:0] lk_addr;
    logic        lload_req = 1'b0;
    logic [15:0] lload_sel = '0;
    logic        lload_done;
    logic [1:0]  lload_status;
    logic        busy;
    logic [15:0] lsel_q;
    logic [31:0] lbase_q;
    logic [19:0] llim_q;
    logic        lvalid_q;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_valid = 1'b0;
    logic [63:0] mem_data = '0;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    desc_table_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .tab_wr_en(tab_wr_en), .tab_wr_sel(tab_wr_sel), .tab_wr_data(tab_wr_data),
        .gtab_q(gtab_q), .itab_q(itab_q),
        .lk_req(lk_req), .lk_is_vec(lk_is_vec), .lk_key(lk_key),
        .lk_ack(lk_ack), .lk_status(lk_status), .lk_addr(lk_addr),
        .lload_req(lload_req), .lload_sel(lload_sel),
        .lload_done(lload_done), .lload_status(lload_status), .busy(busy),
        .lsel_q(lsel_q), .lbase_q(lbase_q), .llim_q(llim_q), .lvalid_q(lvalid_q),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_data(mem_data)
    );

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_desc(input logic [31:0] b,
                                            input logic [19:0] l,
                                            input logic p);
        logic [63:0] d;
        d = '0;
        d[63:56] = b[31:24];
        d[39:32] = b[23:16];
        d[31:16] = b[15:0];
        d[51:48] = l[19:16];
        d[15:0]  = l[15:0];
        d[47]    = p;
        d[46:40] = 7'h1A;
        return d;
    endfunction

    task automatic wr_tab(input logic sel, input logic [47:0] v);
        @(negedge clk);
        tab_wr_en = 1'b1; tab_wr_sel = sel; tab_wr_data = v;
        @(posedge clk);
        @(negedge clk);
        tab_wr_en = 1'b0;
    endtask

    task automatic lookup(input string tag, input logic is_vec, input logic [15:0] key,
                          input logic [1:0] exp_st, input logic [31:0] exp_addr);
        @(negedge clk);
        lk_req = 1'b1; lk_is_vec = is_vec; lk_key = key;
        @(posedge clk);
        @(negedge clk);
        lk_req = 1'b0;
        check(tag, "lk_ack", 64'(lk_ack), 64'd1);
        check(tag, "lk_status", 64'(lk_status), 64'(exp_st));
        check(tag, "lk_addr", 64'(lk_addr), 64'(exp_addr));
    endtask

    task automatic load_now(input string tag, input logic [15:0] sel,
                            input logic [1:0] exp_st);
        @(negedge clk);
        lload_req = 1'b1; lload_sel = sel;
        @(posedge clk);
        @(negedge clk);
        lload_req = 1'b0;
        check(tag, "lload_done", 64'(lload_done), 64'd1);
        check(tag, "lload_status", 64'(lload_status), 64'(exp_st));
        check(tag, "mem_req", 64'(mem_req), 64'd0);
    endtask

    task automatic load_fetch(input string tag, input logic [15:0] sel,
                              input logic [31:0] exp_addr, input logic [63:0] d,
                              input logic [1:0] exp_st);
        @(negedge clk);
        lload_req = 1'b1; lload_sel = sel;
        @(posedge clk);
        @(negedge clk);
        lload_req = 1'b0;
        check(tag, "mem_req", 64'(mem_req), 64'd1);
        check(tag, "mem_addr", 64'(mem_addr), 64'(exp_addr));
        check(tag, "busy", 64'(busy), 64'd1);
        for (int k = 0; k < 3; k++) begin
            lk_req = 1'b1; lk_is_vec = 1'b1; lk_key = 16'h0001;
            lload_req = 1'b1; lload_sel = 16'h0008;
            @(posedge clk);
            @(negedge clk);
            lk_req = 1'b0; lload_req = 1'b0;
            check("R10", "lk_ack while busy", 64'(lk_ack), 64'd0);
            check("R8", "mem_addr held", 64'(mem_addr), 64'(exp_addr));
            check("R10", "lload_done while busy", 64'(lload_done), 64'd0);
        end
        mem_valid = 1'b1; mem_data = d;
        @(posedge clk);
        @(negedge clk);
        mem_valid = 1'b0; mem_data = '0;
        check(tag, "lload_done", 64'(lload_done), 64'd1);
        check(tag, "lload_status", 64'(lload_status), 64'(exp_st));
        check("R10", "busy after fetch", 64'(busy), 64'd0);
    endtask

    task automatic t_reset();
        check("R11", "gtab_q", 64'(gtab_q), 64'd0);
        check("R11", "itab_q", 64'(itab_q), 64'd0);
        check("R11", "lvalid_q", 64'(lvalid_q), 64'd0);
        check("R11", "lbase_q", 64'(lbase_q), 64'd0);
        check("R11", "mem_req", 64'(mem_req), 64'd0);
        check("R11", "busy", 64'(busy), 64'd0);
        check("R11", "lk_ack", 64'(lk_ack), 64'd0);
        check("R11", "lload_done", 64'(lload_done), 64'd0);
    endtask

    task automatic t_regs();
        wr_tab(1'b0, {32'h0001_0000, 16'h00FF});
        check("R1", "gtab_q", 64'(gtab_q), 64'({32'h0001_0000, 16'h00FF}));
        wr_tab(1'b1, {32'h0002_0000, 16'h07FF});
        check("R1", "itab_q", 64'(itab_q), 64'({32'h0002_0000, 16'h07FF}));
        check("R1", "gtab_q kept", 64'(gtab_q), 64'({32'h0001_0000, 16'h00FF}));
    endtask

    task automatic t_global();
        lookup("R2", 1'b0, 16'h0010, 2'd0, 32'h0001_0010);
        lookup("R4", 1'b0, 16'h00F8, 2'd0, 32'h0001_00F8);
        lookup("R4", 1'b0, 16'h0100, 2'd2, 32'h0);
        lookup("R3", 1'b0, 16'h0003, 2'd1, 32'h0);
    endtask

    task automatic t_vector();
        lookup("R5", 1'b1, 16'h0005, 2'd0, 32'h0002_0028);
        lookup("R5", 1'b1, 16'h00FF, 2'd0, 32'h0002_07F8);
        wr_tab(1'b1, {32'h0002_0000, 16'h00FF});
        lookup("R5", 1'b1, 16'h001F, 2'd0, 32'h0002_00F8);
        lookup("R5", 1'b1, 16'h0020, 2'd2, 32'h0);
        wr_tab(1'b1, {32'h0002_0000, 16'h07FF});
    endtask

    task automatic t_local_quick();
        lookup("R6", 1'b0, 16'h000C, 2'd3, 32'h0);
        load_now("R7", 16'h0014, 2'd3);
        check("R7", "lvalid_q kept", 64'(lvalid_q), 64'd0);
        check("R7", "lsel_q kept", 64'(lsel_q), 64'd0);
        load_now("R8", 16'h0200, 2'd2);
        check("R8", "lsel_q kept", 64'(lsel_q), 64'd0);
    endtask

    task automatic t_local_fetch();
        load_fetch("R9", 16'h0028, 32'h0001_0028,
                   mk_desc(32'h1234_5678, 20'h0001F, 1'b1), 2'd0);
        check("R9", "lbase_q", 64'(lbase_q), 64'h1234_5678);
        check("R9", "llim_q", 64'(llim_q), 64'h0001F);
        check("R9", "lvalid_q", 64'(lvalid_q), 64'd1);
        check("R9", "lsel_q", 64'(lsel_q), 64'h0028);
        lookup("R2", 1'b0, 16'h001C, 2'd0, 32'h1234_5690);
        lookup("R4", 1'b0, 16'h0024, 2'd2, 32'h0);
        lookup("R3", 1'b0, 16'h0004, 2'd0, 32'h1234_5678);
        load_fetch("R9", 16'h0030, 32'h0001_0030,
                   mk_desc(32'hAAAA_0000, 20'hFFFFF, 1'b0), 2'd3);
        check("R9", "lbase_q kept", 64'(lbase_q), 64'h1234_5678);
        check("R9", "lsel_q kept", 64'(lsel_q), 64'h0028);
        check("R9", "lvalid_q kept", 64'(lvalid_q), 64'd1);
        load_fetch("R9", 16'h0038, 32'h0001_0038,
                   mk_desc(32'h0040_0000, 20'h1_0000, 1'b1), 2'd0);
        lookup("R4", 1'b0, 16'hFFFC, 2'd0, 32'h0040_FFF8);
    endtask

    task automatic t_null_load();
        load_now("R7", 16'h0000, 2'd1);
        check("R7", "lvalid_q", 64'(lvalid_q), 64'd0);
        check("R7", "lsel_q", 64'(lsel_q), 64'h0000);
        lookup("R6", 1'b0, 16'h001C, 2'd3, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_global();
        t_vector();
        t_local_quick();
        t_local_fetch();
        t_null_load();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule